// File: doc/BRIEF.md
# Run/Step Clock-Enable and Reset Controller

This block turns one free-running system clock into a single-cycle advance enable for a move-only processor, together with a clean reset. The clock itself is never gated: every register of the processor stays on the system clock and moves only in cycles where the advance enable is high. A run switch chooses between free running and stepping. While running, a rate select chooses between an advance every cycle and a slower rate made by a clock divider. While stopped, each debounced press of the step button gives exactly one advance.

The processor can raise a break request. When the controller is free running, a break drops it into a halted state, where the step button works as it does in stop mode. The halted state lasts until the run switch is turned off. The reset button forces reset at once, without waiting for a clock edge. Reset is released on a clock edge once the button has stayed low for a debounce interval. The first advance comes one cycle after release, so the sequencer and the program counter leave reset together and start at address zero.

Top module: `runstep_ctrl`

## Requirements
- R1: Raising `reset_btn` sets `rst_out` high and `adv_en` low at once, without waiting for a clock edge. `adv_en` is never high in a cycle where `rst_out` is high.
- R2: After `reset_btn` falls, `rst_out` stays high for exactly SYNC_STAGES+DEB_CYCLES sampled cycles and then falls. This is always at least two clocks. If the button goes high again before that, the count starts over.
- R3: With run on, fast selected and no break, `adv_en` is high in every cycle.
- R4: With run on and slow selected, `adv_en` is a one-cycle pulse once every SLOW_DIV cycles.
- R5: With run off and no step press, `adv_en` stays low.
- R6: In stop mode, a step press held for at least DEB_CYCLES+3 cycles gives exactly one `adv_en` pulse. A press shorter than DEB_CYCLES-2 cycles gives none.
- R7: Step presses have no effect while free running: the slow-rate pulse count over a window is unchanged.
- R8: A break request that is high for one cycle while running stops `adv_en` within two cycles. `adv_en` then stays low after the request goes away.
- R9: While halted by a break, each valid step press gives exactly one `adv_en` pulse.
- R10: Turning run off and then on again clears the halt, and free running resumes.
- R11: With run on and fast selected during reset, `adv_en` is low in the first cycle after `rst_out` falls and high in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| reset_btn | input | 1 | Reset button, active high, asynchronous |
| run_sw | input | 1 | 1 = free run, 0 = stop/step |
| fast_sel | input | 1 | 1 = advance every cycle, 0 = divided rate |
| step_btn | input | 1 | Step button, active high, raw |
| brk_req | input | 1 | Break request from the processor, synchronous |
| adv_en | output | 1 | One-cycle advance enable |
| rst_out | output | 1 | Reset to the processor, released synchronously |

## Verification
Switch inputs pass through SYNC_STAGES flops and one output register, so a change of run or rate shows on `adv_en` three cycles later. The bench waits at least four cycles after each such change before it counts. A break is seen at the second clock edge after it is driven, and the bench samples from that point on. Reset release is counted exactly as SYNC_STAGES+DEB_CYCLES high samples, and the first advance is checked one cycle after that. Step presses are judged by counting pulses over a window that covers the press and the debounce of its release. This avoids depending on the exact debounce edge, and random press lengths stay at least two cycles away from the threshold.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
package rsc_pkg;
   // Operator switches that share one synchronizer
   typedef struct packed {
      logic run;
      logic fast;
      logic step;
   } rsc_sw_t;

   localparam int unsigned RSC_MIN_SYNC = 2;
endpackage

// File: rtl/rsc_sync.sv
`timescale 1ns/1ps
module rsc_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         arst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("rsc_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] st;
      always_ff @(posedge clk or posedge arst) begin
         if (arst) st <= '0;
         else      st <= d;
      end
      assign q = st;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] st;
      always_ff @(posedge clk or posedge arst) begin
         if (arst) st <= '0;
         else      st <= {st[STAGES-2:0], d};
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/rsc_debounce.sv
`timescale 1ns/1ps
module rsc_debounce #(
   parameter int unsigned DEB = 16
) (
   input  logic clk,
   input  logic arst,
   input  logic din,
   output logic rise
);
   localparam int unsigned CW   = $clog2(DEB + 1);
   localparam logic [CW-1:0] LAST = CW'(DEB - 1);

   if (DEB < 1) begin : g_bad_deb
      $error("rsc_debounce: DEB must be at least 1");
   end

   logic          level;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         level <= 1'b0;
         cnt   <= '0;
         rise  <= 1'b0;
      end else begin
         rise <= 1'b0;
         if (din != level) begin
            if (cnt == LAST) begin
               level <= din;
               cnt   <= '0;
               rise  <= din;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/rsc_rate.sv
`timescale 1ns/1ps
module rsc_rate #(
   parameter int unsigned DIV = 8
) (
   input  logic clk,
   input  logic arst,
   input  logic clr,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("rsc_rate: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick = 1'b1;
   end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      assign tick = (cnt == LAST);
      always_ff @(posedge clk or posedge arst) begin
         if (arst)      cnt <= '0;
         else if (clr)  cnt <= '0;
         else if (tick) cnt <= '0;
         else           cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rsc_rstgen.sv
`timescale 1ns/1ps
module rsc_rstgen #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned HOLD   = 16
) (
   input  logic clk,
   input  logic arst,
   output logic rst_q
);
   localparam int unsigned CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] DONE = CW'(HOLD);

   if (HOLD < 1) begin : g_bad_hold
      $error("rsc_rstgen: HOLD must be at least 1");
   end

   logic          rel;
   logic [CW-1:0] cnt;

   rsc_sync #(.W(1), .STAGES(STAGES)) u_rel_sync (
      .clk (clk),
      .arst(arst),
      .d   (1'b1),
      .q   (rel)
   );

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         cnt   <= '0;
         rst_q <= 1'b1;
      end else begin
         if (!rel)             cnt <= '0;
         else if (cnt != DONE) cnt <= cnt + 1'b1;
         rst_q <= (cnt != DONE);
      end
   end
endmodule

// File: rtl/runstep_ctrl.sv
`timescale 1ns/1ps
module runstep_ctrl #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEB_CYCLES  = 16,
   parameter int unsigned SLOW_DIV    = 8
) (
   input  logic clk,
   input  logic reset_btn,
   input  logic run_sw,
   input  logic fast_sel,
   input  logic step_btn,
   input  logic brk_req,
   output logic adv_en,
   output logic rst_out
);
   import rsc_pkg::*;

   if (SYNC_STAGES < RSC_MIN_SYNC) begin : g_bad_sync
      $error("runstep_ctrl: SYNC_STAGES below minimum");
   end

   rsc_sw_t sw_raw, sw_s;
   logic    run_s, fast_s;
   logic    step_rise;
   logic    rst_q;
   logic    slow_tick;
   logic    brk_q, halted_q, adv_q;
   logic    run_active, stepping, free_tick, adv_d;

   assign sw_raw = '{run: run_sw, fast: fast_sel, step: step_btn};

   rsc_sync #(.W($bits(rsc_sw_t)), .STAGES(SYNC_STAGES)) u_sw_sync (
      .clk (clk),
      .arst(reset_btn),
      .d   (sw_raw),
      .q   (sw_s)
   );

   assign run_s  = sw_s.run;
   assign fast_s = sw_s.fast;

   rsc_debounce #(.DEB(DEB_CYCLES)) u_step_deb (
      .clk (clk),
      .arst(reset_btn),
      .din (sw_s.step),
      .rise(step_rise)
   );

   rsc_rstgen #(.STAGES(SYNC_STAGES), .HOLD(DEB_CYCLES)) u_rst (
      .clk  (clk),
      .arst (reset_btn),
      .rst_q(rst_q)
   );

   rsc_rate #(.DIV(SLOW_DIV)) u_rate (
      .clk (clk),
      .arst(reset_btn),
      .clr (rst_q),
      .tick(slow_tick)
   );

   always_comb begin
      run_active = run_s && !halted_q && !brk_q;
      stepping   = !run_s || halted_q;
      free_tick  = fast_s || slow_tick;
      adv_d      = (run_active && free_tick) || (stepping && step_rise);
   end

   always_ff @(posedge clk or posedge reset_btn) begin
      if (reset_btn) begin
         brk_q    <= 1'b0;
         halted_q <= 1'b0;
         adv_q    <= 1'b0;
      end else if (rst_q) begin
         brk_q    <= 1'b0;
         halted_q <= 1'b0;
         adv_q    <= 1'b0;
      end else begin
         brk_q    <= brk_req;
         halted_q <= run_s && (halted_q || brk_q);
         adv_q    <= adv_d;
      end
   end

   assign adv_en  = adv_q;
   assign rst_out = rst_q;
endmodule

// File: rtl/runstep_ctrl_chk.sv
`timescale 1ns/1ps
module runstep_ctrl_chk (
   input logic clk,
   input logic reset_btn,
   input logic rst_out,
   input logic adv_en,
   input logic halted,
   input logic run_s,
   input logic brk_q,
   input logic step_rise
);
   // R1
   adv_in_rst_chk: assert property (@(posedge clk) disable iff (reset_btn)
      rst_out |-> !adv_en);

   // R2
   rst_hold_chk: assert property (@(posedge clk) disable iff (reset_btn)
      $fell(rst_out) |-> $past(rst_out, 2));

   // R10
   halt_sticky_chk: assert property (@(posedge clk) disable iff (reset_btn)
      (halted && run_s) |=> halted);

   // R8
   brk_stop_chk: assert property (@(posedge clk) disable iff (reset_btn)
      (brk_q && run_s && !halted) |=> !adv_en);

   // R6
   step_one_chk: assert property (@(posedge clk) disable iff (reset_btn)
      step_rise |=> !step_rise);
endmodule

bind runstep_ctrl runstep_ctrl_chk u_chk (
   .clk      (clk),
   .reset_btn(reset_btn),
   .rst_out  (rst_out),
   .adv_en   (adv_en),
   .halted   (halted_q),
   .run_s    (run_s),
   .brk_q    (brk_q),
   .step_rise(step_rise)
);

// File: tb/runstep_ctrl_test.sv
`timescale 1ns/1ps
module runstep_ctrl_test;
   localparam int SYNC = 2;
   localparam int DEB  = 16;
   localparam int DIV  = 8;

   logic clk = 1'b0;
   logic reset_btn, run_sw, fast_sel, step_btn, brk_req;
   logic adv_en, rst_out;
   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;

   runstep_ctrl #(.SYNC_STAGES(SYNC), .DEB_CYCLES(DEB), .SLOW_DIV(DIV)) uut (
      .clk(clk), .reset_btn(reset_btn), .run_sw(run_sw), .fast_sel(fast_sel),
      .step_btn(step_btn), .brk_req(brk_req), .adv_en(adv_en), .rst_out(rst_out)
   );

   always #4 clk = ~clk;

   task automatic cyc(input int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_adv(input int n, output int c);
      c = 0;
      repeat (n) begin
         cyc(1);
         c += int'(adv_en);
      end
   endtask

   // pulses seen over a press of d cycles plus its release settling
   task automatic press(input int d, output int c);
      int t;
      c = 0;
      step_btn = 1'b1;
      count_adv(d, t);
      c += t;
      step_btn = 1'b0;
      count_adv(3 * DEB, t);
      c += t;
   endtask

   function automatic int exp_press(input int d);
      return (d >= DEB) ? 1 : 0;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int k, c, d;
      int unsigned r;
      r = $urandom(20240611);
      reset_btn = 1'b1; run_sw = 1'b1; fast_sel = 1'b1;
      step_btn = 1'b0; brk_req = 1'b0;
      cyc(5);
      chk(rst_out == 1'b1 && adv_en == 1'b0, "R1 reset state", int'(rst_out), 1);

      // R2 / R11: exact release and first advance
      reset_btn = 1'b0;
      k = 0;
      cyc(1);
      while (rst_out && k < 200) begin k++; cyc(1); end
      chk(k == SYNC + DEB, "R2 release length", k, SYNC + DEB);
      chk(adv_en == 1'b0, "R11 first cycle after release", int'(adv_en), 0);
      cyc(1);
      chk(adv_en == 1'b1, "R11 first advance", int'(adv_en), 1);

      // R3 fast run
      count_adv(20, c);
      chk(c == 20, "R3 fast run count", c, 20);

      // R4 slow run
      fast_sel = 1'b0;
      cyc(4);
      count_adv(8 * DIV, c);
      chk(c == 8, "R4 slow run count", c, 8);
      k = 0;
      while (!adv_en && k < 4 * DIV) begin k++; cyc(1); end
      cyc(1);
      chk(adv_en == 1'b0, "R4 pulse width", int'(adv_en), 0);
      k = 1;
      while (!adv_en && k < 4 * DIV) begin k++; cyc(1); end
      chk(k == DIV, "R4 pulse spacing", k, DIV);

      // R7 step ignored while running
      step_btn = 1'b1;
      c = 0;
      for (int i = 0; i < 10 * DIV; i++) begin
         if (i == 2 * DEB) step_btn = 1'b0;
         cyc(1);
         c += int'(adv_en);
      end
      chk(c == 10, "R7 step ignored in run", c, 10);

      // R5 stop with no press
      run_sw = 1'b0;
      cyc(4);
      count_adv(40, c);
      chk(c == 0, "R5 stopped idle", c, 0);

      // R6 directed and random presses
      press(DEB + 3, c);
      chk(c == 1, "R6 long press", c, 1);
      press(DEB - 3, c);
      chk(c == 0, "R6 short press", c, 0);
      for (int i = 0; i < 8; i++) begin
         if ($urandom % 2 == 0) d = DEB + 3 + int'($urandom % (2 * DEB));
         else                   d = 1 + int'($urandom % (DEB - 3));
         press(d, c);
         chk(c == exp_press(d), "R6 random press", c, exp_press(d));
      end

      // R8 break while running
      run_sw = 1'b1; fast_sel = 1'b1;
      cyc(4);
      chk(adv_en == 1'b1, "R8 running before break", int'(adv_en), 1);
      brk_req = 1'b1;
      cyc(1);
      brk_req = 1'b0;
      cyc(1);
      count_adv(30, c);
      chk(c == 0, "R8 halted after break", c, 0);

      // R9 step while halted
      press(DEB + 5, c);
      chk(c == 1, "R9 step while halted", c, 1);
      press(2, c);
      chk(c == 0, "R9 glitch while halted", c, 0);

      // R10 run toggle resumes
      run_sw = 1'b0;
      cyc(6);
      run_sw = 1'b1;
      cyc(4);
      count_adv(20, c);
      chk(c == 20, "R10 resume after toggle", c, 20);

      // R1 asynchronous assertion mid-cycle
      #1 reset_btn = 1'b1;
      #1;
      chk(rst_out == 1'b1 && adv_en == 1'b0, "R1 async assert", int'(rst_out), 1);
      cyc(3);

      // R2 bounce restarts the release count
      reset_btn = 1'b0;
      cyc(DEB / 2);
      chk(rst_out == 1'b1, "R2 held during bounce", int'(rst_out), 1);
      reset_btn = 1'b1;
      cyc(2);
      reset_btn = 1'b0;
      k = 0;
      cyc(1);
      while (rst_out && k < 200) begin k++; cyc(1); end
      chk(k == SYNC + DEB, "R2 release after bounce", k, SYNC + DEB);
      cyc(1);
      chk(adv_en == 1'b1, "R11 advance after second release", int'(adv_en), 1);

      finish_run();
   end
endmodule